// File: doc/BRIEF.md
# Serial Slave Read Port with Ready Request

This block is the read side of a slave control port on a two-wire serial bus (I2C style). Logic inside the chip writes a byte into a one-entry holding register with a strobe. An active-low request line tells the bus master that a byte is waiting. The master then runs a read transaction: START, the 7-bit slave address MSB first, a read/write bit of 1, and an acknowledge clock. The port then shifts the byte out MSB first on SDA and waits for the master's acknowledge clock.

The block runs on a fast system clock. It oversamples SCL and SDA through synchronizers and edge detectors. The request line tells the master whether a further byte follows in the same transaction. If a byte arrives in time, it is chained straight into the shift register. If it arrives late, it is held back for a fresh transaction. The port also records, at reset or at a software reset pulse, whether the chip-select input selects the alternate serial (SPI) mode. In that mode the two-wire engine stays silent.

Top module: `srp_read_port`

## Requirements
- R1: After reset, with the holding register empty, `req_n` is 1, `sda_oe` is 0 and `overrun` is 0. With `cs_n` high, `spi_mode` is 0.
- R2: A `wr_stb` pulse while the holding register is empty stores `wr_data` and drives `req_n` low. A `wr_stb` while it is full leaves the stored byte unchanged and raises `overrun` for exactly one clock.
- R3: After a START, the port receives 8 bits MSB first on rising SCL edges: the 7-bit address, then the read/write bit. It pulls SDA low for the 9th clock only when the address equals `SLAVE_ADDR` and the read/write bit is 1. On any other frame it drives nothing and leaves the holding register untouched until the next START.
- R4: On the falling SCL edge that ends the address acknowledge clock, the held byte moves into the shift register and the full flag clears, so `req_n` goes high. The port then presents the byte MSB first, one bit per SCL clock. SDA changes only after SCL falls and is stable while SCL is high. With an empty holding register the port presents 8'hFF.
- R5: If the holding register is empty at the rising SCL edge of the last data bit, `req_n` is high after that edge. It stays high until the rising SCL edge of the master's acknowledge clock, even if a byte is written in between.
- R6: If the holding register is full at the rising SCL edge of the last data bit, `req_n` stays low. The byte moves into the shift register on the falling edge of the master's acknowledge clock and shifts out on the next 8 SCL clocks without a new address. This happens whatever value the master drives in that acknowledge bit.
- R7: A byte written after the last data bit's rising edge but before the acknowledge clock's rising edge is not chained. `req_n` goes low only after the acknowledge rising edge, SDA is released after the acknowledge clock, and the byte is delivered by the next read transaction.
- R8: A STOP condition while a byte sits in the shift register does not halt shifting. The following SCL clocks keep presenting the remaining bits.
- R9: `cs_n` is sampled on the first clock after the reset is released and on every clock with `soft_rst` high. A sampled 0 sets `spi_mode` to 1 and a sampled 1 clears it. The value holds between samples. While `spi_mode` is 1, the port never drives SDA and gives no acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| soft_rst | input | 1 | Synchronous software reset: re-samples `cs_n`, returns the bus engine to idle |
| cs_n | input | 1 | Chip select, sampled for mode selection |
| scl_in | input | 1 | Serial clock from the bus |
| sda_in | input | 1 | Serial data as seen on the bus |
| sda_o | output | 1 | Value driven on SDA when enabled |
| sda_oe | output | 1 | SDA drive enable (0 = released) |
| wr_stb | input | 1 | Load strobe for the holding register |
| wr_data | input | 8 | Byte to load |
| req_n | output | 1 | Active-low byte-ready request to the master |
| overrun | output | 1 | One-clock pulse when a write hits a full holding register |
| spi_mode | output | 1 | 1 when the sampled chip select selected SPI mode |

## Verification
The assertions assume that each SCL level lasts several system clocks, longer than the synchronizer delay. They also assume the master changes SDA only while SCL is low, except to form START and STOP, so that a bit edge and a bus condition never reach the edge detectors in the same cycle. The bench holds each quarter of an SCL period for four system clocks and moves SDA at mid-low. It models the bus as a wired-AND of the master and the port. It forms the STOP inside a data byte only while the port itself presents a 1.

// File: rtl/srp_pkg.sv
`timescale 1ns/1ps
package srp_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_AACK,
    ST_DATA,
    ST_MACK
  } srp_state_e;
endpackage

// File: rtl/srp_sync_edge.sv
`timescale 1ns/1ps
module srp_sync_edge #(
  parameter int STAGES   = 2,
  parameter bit IDLE_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_ni,
  input  logic d_i,
  output logic lvl_o,
  output logic rise_o,
  output logic fall_o
);
  logic [STAGES:0] pipe_q;

  for (genvar g = 0; g <= STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_ni) begin
        if (!rst_ni) pipe_q[0] <= IDLE_VAL;
        else         pipe_q[0] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_ni) begin
        if (!rst_ni) pipe_q[g] <= IDLE_VAL;
        else         pipe_q[g] <= pipe_q[g-1];
      end
    end
  end

  assign lvl_o  = pipe_q[STAGES-1];
  assign rise_o = pipe_q[STAGES-1] & ~pipe_q[STAGES];
  assign fall_o = ~pipe_q[STAGES-1] & pipe_q[STAGES];
endmodule

// File: rtl/srp_hold_reg.sv
`timescale 1ns/1ps
module srp_hold_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_ni,
  input  logic         wr_stb_i,
  input  logic [W-1:0] wr_data_i,
  input  logic         take_i,
  output logic [W-1:0] held_o,
  output logic         full_o,
  output logic         ovr_o
);
  logic [W-1:0] data_q, data_d;
  logic         full_q, full_d, ovr_q, ovr_d;

  always_comb begin
    data_d = data_q;
    full_d = full_q;
    ovr_d  = 1'b0;
    if (wr_stb_i && full_q) begin
      ovr_d = 1'b1;
    end else if (wr_stb_i) begin
      data_d = wr_data_i;
      full_d = 1'b1;
    end
    if (take_i) full_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q <= '0;
      full_q <= 1'b0;
      ovr_q  <= 1'b0;
    end else begin
      data_q <= data_d;
      full_q <= full_d;
      ovr_q  <= ovr_d;
    end
  end

  assign held_o = data_q;
  assign full_o = full_q;
  assign ovr_o  = ovr_q;

  // R2
  ovr_keep_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (wr_stb_i && full_q) |=> (ovr_o && $stable(held_o)));
  // R2
  fill_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (wr_stb_i && !full_q && !take_i) |=> (full_o && held_o == $past(wr_data_i)));
  // R4
  take_clear_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    take_i |=> !full_o);
endmodule

// File: rtl/srp_mode_latch.sv
`timescale 1ns/1ps
module srp_mode_latch (
  input  logic clk,
  input  logic rst_ni,
  input  logic soft_rst_i,
  input  logic cs_n_i,
  output logic spi_mode_o
);
  logic cap_q, spi_q, spi_d;

  always_comb begin
    spi_d = spi_q;
    if (cap_q || soft_rst_i) spi_d = ~cs_n_i;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      cap_q <= 1'b1;
      spi_q <= 1'b0;
    end else begin
      cap_q <= 1'b0;
      spi_q <= spi_d;
    end
  end

  assign spi_mode_o = spi_q;

  // R9
  mode_cap_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    soft_rst_i |=> (spi_mode_o == !$past(cs_n_i)));
endmodule

// File: rtl/srp_read_port.sv
`timescale 1ns/1ps
module srp_read_port
  import srp_pkg::*;
#(
  parameter int                ADDR_W      = 7,
  parameter int                DATA_W      = 8,
  parameter int                SYNC_STAGES = 2,
  parameter logic [ADDR_W-1:0] SLAVE_ADDR  = 7'h3A
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              soft_rst,
  input  logic              cs_n,
  input  logic              scl_in,
  input  logic              sda_in,
  output logic              sda_o,
  output logic              sda_oe,
  input  logic              wr_stb,
  input  logic [DATA_W-1:0] wr_data,
  output logic              req_n,
  output logic              overrun,
  output logic              spi_mode
);
  localparam int AFRAME = ADDR_W + 1;
  localparam int MAXB   = (AFRAME > DATA_W) ? AFRAME : DATA_W;
  localparam int CNT_W  = $clog2(MAXB + 1);

  // reset: asynchronous assert, synchronous release
  logic rs1_q, rs2_q, rst_ni;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs1_q <= 1'b0;
      rs2_q <= 1'b0;
    end else begin
      rs1_q <= 1'b1;
      rs2_q <= rs1_q;
    end
  end
  assign rst_ni = rs2_q;

  logic scl_lvl, scl_rise, scl_fall, sda_lvl, sda_rise, sda_fall;
  srp_sync_edge #(.STAGES(SYNC_STAGES), .IDLE_VAL(1'b1)) u_scl (
    .clk(clk), .rst_ni(rst_ni), .d_i(scl_in),
    .lvl_o(scl_lvl), .rise_o(scl_rise), .fall_o(scl_fall));
  srp_sync_edge #(.STAGES(SYNC_STAGES), .IDLE_VAL(1'b1)) u_sda (
    .clk(clk), .rst_ni(rst_ni), .d_i(sda_in),
    .lvl_o(sda_lvl), .rise_o(sda_rise), .fall_o(sda_fall));

  logic start_det, stop_det;
  assign start_det = sda_fall & scl_lvl;
  assign stop_det  = sda_rise & scl_lvl;

  logic              take, full;
  logic [DATA_W-1:0] held;
  srp_hold_reg #(.W(DATA_W)) u_hold (
    .clk(clk), .rst_ni(rst_ni), .wr_stb_i(wr_stb), .wr_data_i(wr_data),
    .take_i(take), .held_o(held), .full_o(full), .ovr_o(overrun));

  srp_mode_latch u_mode (
    .clk(clk), .rst_ni(rst_ni), .soft_rst_i(soft_rst), .cs_n_i(cs_n),
    .spi_mode_o(spi_mode));

  srp_state_e        state_q, state_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [AFRAME-1:0] addr_q, addr_d;
  logic [DATA_W-1:0] shreg_q, shreg_d;
  logic              chain_q, chain_d, block_q, block_d;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    addr_d  = addr_q;
    shreg_d = shreg_q;
    chain_d = chain_q;
    block_d = block_q;
    take    = 1'b0;
    if (soft_rst || spi_mode) begin
      state_d = ST_IDLE;
      cnt_d   = '0;
      chain_d = 1'b0;
      block_d = 1'b0;
    end else if (start_det) begin
      state_d = ST_ADDR;
      cnt_d   = '0;
      chain_d = 1'b0;
      block_d = 1'b0;
    end else begin
      case (state_q)
        ST_ADDR: begin
          if (stop_det) begin
            state_d = ST_IDLE;
          end else if (scl_rise) begin
            addr_d = {addr_q[AFRAME-2:0], sda_lvl};
            cnt_d  = cnt_q + CNT_W'(1);
          end else if (scl_fall && cnt_q == CNT_W'(AFRAME)) begin
            cnt_d   = '0;
            state_d = (addr_q[AFRAME-1:1] == SLAVE_ADDR && addr_q[0]) ? ST_AACK : ST_IDLE;
          end
        end
        ST_AACK: begin
          if (scl_rise) begin
            cnt_d = CNT_W'(1);
          end else if (scl_fall && cnt_q == CNT_W'(1)) begin
            state_d = ST_DATA;
            cnt_d   = '0;
            take    = full;
            shreg_d = full ? held : '1;
          end
        end
        ST_DATA: begin
          if (scl_rise) begin
            cnt_d = cnt_q + CNT_W'(1);
            if (cnt_q == CNT_W'(DATA_W - 1)) begin
              if (full) chain_d = 1'b1;
              else      block_d = 1'b1;
            end
          end else if (scl_fall && cnt_q != '0) begin
            if (cnt_q == CNT_W'(DATA_W)) begin
              state_d = ST_MACK;
              cnt_d   = '0;
            end else begin
              shreg_d = {shreg_q[DATA_W-2:0], 1'b1};
            end
          end
        end
        ST_MACK: begin
          if (scl_rise) begin
            cnt_d   = CNT_W'(1);
            block_d = 1'b0;
          end else if (scl_fall && cnt_q == CNT_W'(1)) begin
            cnt_d   = '0;
            chain_d = 1'b0;
            if (chain_q) begin
              state_d = ST_DATA;
              take    = 1'b1;
              shreg_d = held;
            end else begin
              state_d = ST_IDLE;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      addr_q  <= '0;
      shreg_q <= '1;
      chain_q <= 1'b0;
      block_q <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      addr_q  <= addr_d;
      shreg_q <= shreg_d;
      chain_q <= chain_d;
      block_q <= block_d;
    end
  end

  assign sda_oe = (state_q == ST_AACK) || (state_q == ST_DATA);
  assign sda_o  = (state_q == ST_DATA) ? shreg_q[DATA_W-1] : 1'b0;
  assign req_n  = ~full | block_q;

  // R4
  sda_hold_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (scl_lvl && $past(scl_lvl) && !$past(start_det) && !$past(soft_rst))
      |-> ($stable(sda_oe) && $stable(sda_o)));
  // R5
  req_block_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (state_q == ST_DATA && scl_rise && cnt_q == CNT_W'(DATA_W - 1) && !full
       && !soft_rst && !spi_mode && !start_det) |=> req_n);
  // R6
  chain_load_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (state_q == ST_MACK && scl_fall && cnt_q == CNT_W'(1) && chain_q
       && !soft_rst && !spi_mode && !start_det) |=> (sda_oe && !full));
  // R9
  spi_quiet_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    spi_mode |-> !sda_oe);
endmodule

// File: tb/tb_srp_read_port.sv
`timescale 1ns/1ps
module tb_srp_read_port;
  localparam logic [6:0] ADDR  = 7'h3A;
  localparam logic [7:0] BYTE_A = 8'hC3;
  localparam logic [7:0] BYTE_B = 8'h6E;
  localparam logic [7:0] BYTE_C = 8'hB5;

  logic clk, rst_n, soft_rst, cs_n, scl, m_sda, wr_stb;
  logic [7:0] wr_data;
  logic sda_o, sda_oe, req_n, overrun, spi_mode, sda_bus;

  assign sda_bus = m_sda & ~(sda_oe & ~sda_o);

  srp_read_port #(.SLAVE_ADDR(ADDR)) dut (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .cs_n(cs_n),
    .scl_in(scl), .sda_in(sda_bus), .sda_o(sda_o), .sda_oe(sda_oe),
    .wr_stb(wr_stb), .wr_data(wr_data), .req_n(req_n),
    .overrun(overrun), .spi_mode(spi_mode));

  initial clk = 1'b0;
  always #5 clk = ~clk;

  int checks = 0;
  int errs   = 0;
  logic [7:0] exp_q[$];
  logic [7:0] got_byte;
  logic       got_stb = 1'b0;

  task automatic chk(input logic ok, input string what, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s: actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  // scoreboard monitor
  always @(posedge got_stb) begin
    logic [7:0] e;
    checks++;
    if (exp_q.size() == 0) begin
      errs++;
      $display("FAIL R4 byte with no expectation: actual=%0h expected=none", got_byte);
    end else begin
      e = exp_q.pop_front();
      if (got_byte !== e) begin
        errs++;
        $display("FAIL R4 byte read: actual=%0h expected=%0h", got_byte, e);
      end
    end
  end

  task automatic expect_byte(input logic [7:0] b);
    exp_q.push_back(b);
  endtask

  task automatic deliver(input logic [7:0] b);
    got_byte = b;
    got_stb  = 1'b1;
    #1 got_stb = 1'b0;
    #9;
  endtask

  task automatic wr_pulse(input logic [7:0] d);
    wr_data = d;
    wr_stb  = 1'b1;
    #10 wr_stb = 1'b0;
  endtask

  task automatic bit_cycle(input logic b, output logic r);
    #40 m_sda = b;
    #40 scl = 1'b1;
    #40 r = sda_bus;
    #40 scl = 1'b0;
  endtask

  task automatic bus_start();
    m_sda = 1'b1;
    #40 scl = 1'b1;
    #40 m_sda = 1'b0;
    #40 scl = 1'b0;
  endtask

  task automatic bus_stop();
    #40 m_sda = 1'b0;
    #40 scl = 1'b1;
    #40 m_sda = 1'b1;
    #40;
  endtask

  task automatic send_addr(input logic [6:0] a, input logic rw, output logic ack);
    logic r;
    bus_start();
    for (int i = 6; i >= 0; i--) bit_cycle(a[i], r);
    bit_cycle(rw, r);
    bit_cycle(1'b1, ack);
  endtask

  task automatic read_bits(input int n, output logic [7:0] v);
    logic r;
    v = 8'h00;
    for (int i = 0; i < n; i++) begin
      bit_cycle(1'b1, r);
      v = {v[6:0], r};
    end
  endtask

  logic done = 1'b0;

  initial begin
    logic ack, r;
    logic [7:0] v;
    rst_n = 1'b0; soft_rst = 1'b0; cs_n = 1'b1; scl = 1'b1; m_sda = 1'b1;
    wr_stb = 1'b0; wr_data = 8'h00;
    #40 rst_n = 1'b1;
    #60;
    chk(req_n == 1'b1, "R1 req_n after reset", {7'd0, req_n}, 8'd1);
    chk(sda_oe == 1'b0, "R1 sda_oe after reset", {7'd0, sda_oe}, 8'd0);
    chk(overrun == 1'b0, "R1 overrun after reset", {7'd0, overrun}, 8'd0);
    chk(spi_mode == 1'b0, "R9 mode with cs_n high", {7'd0, spi_mode}, 8'd0);

    // R2 fill and overrun
    wr_pulse(BYTE_A);
    #10 chk(req_n == 1'b0, "R2 req_n after write", {7'd0, req_n}, 8'd0);
    wr_pulse(8'h11);
    chk(overrun == 1'b1, "R2 overrun pulse", {7'd0, overrun}, 8'd1);
    #10 chk(overrun == 1'b0, "R2 overrun one clock", {7'd0, overrun}, 8'd0);

    // transaction 1: byte A, empty at D0 then late write of B
    expect_byte(BYTE_A);
    send_addr(ADDR, 1'b1, ack);
    chk(ack == 1'b0, "R3 acknowledge on match", {7'd0, ack}, 8'd0);
    #40 chk(req_n == 1'b1, "R4 req_n after load", {7'd0, req_n}, 8'd1);
    read_bits(7, v);
    #40 m_sda = 1'b1;
    #40 scl = 1'b1;
    #40 r = sda_bus;
    chk(req_n == 1'b1, "R5 req_n after D0 rise", {7'd0, req_n}, 8'd1);
    wr_pulse(BYTE_B);
    #30 scl = 1'b0;
    deliver({v[6:0], r});
    #30 m_sda = 1'b0;
    chk(req_n == 1'b1, "R7 req_n before ack rise", {7'd0, req_n}, 8'd1);
    #40 scl = 1'b1;
    #40 chk(req_n == 1'b0, "R7 req_n after ack rise", {7'd0, req_n}, 8'd0);
    #40 scl = 1'b0;
    #40 chk(sda_oe == 1'b0, "R7 late byte not chained", {7'd0, sda_oe}, 8'd0);
    chk(req_n == 1'b0, "R7 late byte kept", {7'd0, req_n}, 8'd0);
    bus_stop();

    // transaction 2: byte B, then chained byte C with STOP inside it
    expect_byte(BYTE_B);
    send_addr(ADDR, 1'b1, ack);
    chk(ack == 1'b0, "R3 acknowledge second read", {7'd0, ack}, 8'd0);
    #40 wr_pulse(BYTE_C);
    chk(req_n == 1'b0, "R6 req_n with next byte", {7'd0, req_n}, 8'd0);
    read_bits(8, v);
    deliver(v);
    chk(req_n == 1'b0, "R6 req_n stays low past D0", {7'd0, req_n}, 8'd0);
    bit_cycle(1'b0, r);
    #40 chk(req_n == 1'b1, "R6 chained byte taken", {7'd0, req_n}, 8'd1);
    chk(sda_oe == 1'b1, "R6 chained byte driven", {7'd0, sda_oe}, 8'd1);
    // D7 of C is 1: form a STOP during its high phase
    m_sda = 1'b0;
    #40 scl = 1'b1;
    #40 m_sda = 1'b1;
    #40 scl = 1'b0;
    read_bits(7, v);
    chk(v[6:0] == BYTE_C[6:0], "R8 shifting after STOP", {1'b0, v[6:0]}, {1'b0, BYTE_C[6:0]});
    bit_cycle(1'b1, r);
    #40 chk(sda_oe == 1'b0, "R6 released after last byte", {7'd0, sda_oe}, 8'd0);
    bus_stop();

    // transaction 3: empty holding register
    expect_byte(8'hFF);
    send_addr(ADDR, 1'b1, ack);
    read_bits(8, v);
    deliver(v);
    bit_cycle(1'b1, r);
    bus_stop();

    // R3 mismatch and write direction
    wr_pulse(8'h5A);
    send_addr(ADDR ^ 7'h01, 1'b1, ack);
    chk(ack == 1'b1, "R3 no ack on other address", {7'd0, ack}, 8'd1);
    read_bits(8, v);
    chk(v == 8'hFF, "R3 bus untouched on mismatch", v, 8'hFF);
    chk(req_n == 1'b0, "R3 holding kept on mismatch", {7'd0, req_n}, 8'd0);
    bus_stop();
    send_addr(ADDR, 1'b0, ack);
    chk(ack == 1'b1, "R3 no ack with rw=0", {7'd0, ack}, 8'd1);
    bus_stop();

    // R9 mode selection
    cs_n = 1'b0;
    soft_rst = 1'b1;
    #10 soft_rst = 1'b0;
    chk(spi_mode == 1'b1, "R9 soft reset with cs_n low", {7'd0, spi_mode}, 8'd1);
    send_addr(ADDR, 1'b1, ack);
    chk(ack == 1'b1, "R9 no ack in spi mode", {7'd0, ack}, 8'd1);
    bus_stop();
    cs_n = 1'b1;
    soft_rst = 1'b1;
    #10 soft_rst = 1'b0;
    chk(spi_mode == 1'b0, "R9 soft reset with cs_n high", {7'd0, spi_mode}, 8'd0);
    cs_n = 1'b0;
    rst_n = 1'b0;
    #40 rst_n = 1'b1;
    #60 chk(spi_mode == 1'b1, "R9 hard reset with cs_n low", {7'd0, spi_mode}, 8'd1);
    cs_n = 1'b1;
    #40 chk(spi_mode == 1'b1, "R9 mode held after reset", {7'd0, spi_mode}, 8'd1);

    #40;
    chk(exp_q.size() == 0, "R4 all expected bytes read", 8'(exp_q.size()), 8'd0);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      #2000000;
    join_any
    if (!done) begin
      checks++;
      errs++;
      $display("FAIL watchdog: actual=running expected=finished");
    end
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule